// File: doc/BRIEF.md
# Chained Expansion Node Shift Register

This block is the serial front end of one expansion board on a chained configuration bus. Every board in the chain holds a single 8-bit shift register. While the chip select is high, the register stays idle. When the chip select falls, the register loads a read byte in parallel. The low nibble of that byte is a fixed board-type code, and the high nibble holds live status and a pending-interrupt flag, all active low. On each rising serial clock edge the register then shifts toward the downstream output, MSB first. Bits from the upstream side enter at the bottom. The host therefore sees each board's byte at its own position in the stream, and that position gives the board's place in the chain. When the chip select rises, whatever the register holds is copied into a write latch. The latch drives four control outputs and four interrupt-mask bits.

The serial pins are oversampled by the block clock through a synchronizer. The serial clock must therefore run well below the block clock. Status and interrupt-source inputs are synchronous to the block clock. The shared interrupt wire is open drain and active low. The block drives it low while any unmasked source is active. There is no streaming data path inside the block, so every pin is plain level signalling with no valid/ready handshake.

Top module: `daisy_node`

## Requirements
- R1: After reset the control outputs equal the parameter CTRL_RST (default 4'b0001, with bit 0 the transmit-disable output asserted). All four mask bits are set, the interrupt drive is off whatever the sources do, and the serial output is 1.
- R2: The read byte loaded at the chip-select fall has bits [3:0] = MODULE_ID. Bit 7 = NOT pending interrupt. Bits [4+i] = NOT status_i[i] for i < STAT_W. Status bits at or above STAT_W up to bit 6 read as 1. A status change after the load does not alter the byte being shifted.
- R3: While the chip select is low, spi_sdo_o presents read-byte bit 7 before the first serial clock rise. It advances by one bit on each serial clock rise, MSB first.
- R4: On each serial clock rise with the chip select low, the bit on spi_sdi_i enters at bit 0. After 8 rises, spi_sdo_o repeats the upstream stream one byte later. In a frame longer than 8 bits, the write latch receives the last 8 bits shifted in.
- R5: The control outputs and mask change only after the chip select rises, never while it is low.
- R6: The latched write byte maps as follows. Bits [3:0] drive ctrl_o[3:0]. Bits [7:4] are mask bits for irq_src_i[3:0], where 1 means masked.
- R7: irq_drive_low_o is 1 one clock after any irq_src_i bit is 1 while its mask bit is 0, and 0 otherwise. The pending flag in the read byte is the same condition.
- R8: Serial clock edges while the chip select is high do not shift the register. spi_sdo_o and the control outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk_i | input | 1 | Serial clock, shift on rising edge |
| spi_cs_n_i | input | 1 | Active-low chip select: fall loads, rise latches |
| spi_sdi_i | input | 1 | Serial data from the upstream side |
| spi_sdo_o | output | 1 | Serial data toward the downstream side (register MSB) |
| status_i | input | STAT_W | Live status inputs, reported inverted |
| irq_src_i | input | 4 | Interrupt source levels |
| ctrl_o | output | 4 | Control outputs from the write latch |
| irq_drive_low_o | output | 1 | Pull-down enable for the shared open-drain interrupt wire |

## Verification
The bench builds the node with MODULE_ID = 1, STAT_W = 2 and two synchronizer stages. With STAT_W below three, read-byte bit 6 has no status source, so the fill-with-one rule becomes observable next to two live inverted status bits. Sixteen-bit frames are run through the default configuration. These place the node in the middle of a chain, showing both the one-byte pass-through delay and the rule that only the final eight shifted bits are latched. The serial clock runs at one sixteenth of the block clock rate, which keeps every serial edge clear of the synchronizer latency.

// File: rtl/daisy_pkg.sv
package daisy_pkg;
  localparam int unsigned FRAME_W = 8;
  localparam int unsigned NIB_W   = FRAME_W / 2;

  typedef logic [FRAME_W-1:0] frame_t;

  typedef struct packed {
    logic [NIB_W-1:0] mask;
    logic [NIB_W-1:0] ctrl;
  } wr_word_t;
endpackage

// File: rtl/daisy_sync.sv
module daisy_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(STAGES); s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < int'(STAGES); s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/daisy_shift.sv
module daisy_shift
  import daisy_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sclk_s,
  input  logic   cs_s,
  input  logic   sdi_s,
  input  frame_t rd_byte,
  output frame_t sr,
  output logic   load,
  output logic   latch,
  output logic   shift
);
  logic sclk_d, cs_d;

  // edge detection on the synchronized levels
  assign load  = cs_d & ~cs_s;
  assign latch = ~cs_d & cs_s;
  assign shift = sclk_s & ~sclk_d & ~cs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
      sr     <= '1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
      if (load)       sr <= rd_byte;
      else if (shift) sr <= {sr[FRAME_W-2:0], sdi_s};
    end
  end
endmodule

// File: rtl/daisy_wlatch.sv
module daisy_wlatch
  import daisy_pkg::*;
#(
  parameter logic [3:0] CTRL_RST = 4'b0001,
  parameter logic [3:0] MASK_RST = 4'hF
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     latch,
  input  frame_t   sr,
  output wr_word_t wr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wr_q <= '{mask: MASK_RST, ctrl: CTRL_RST};
    else if (latch) wr_q <= wr_word_t'(sr);
  end
endmodule

// File: rtl/daisy_irq.sv
module daisy_irq #(
  parameter int unsigned SRC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src,
  input  logic [SRC_W-1:0] mask,
  output logic             pend_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= |(src & ~mask);
  end
endmodule

// File: rtl/daisy_node.sv
module daisy_node
  import daisy_pkg::*;
#(
  parameter logic [3:0]  MODULE_ID   = 4'h1,
  parameter int unsigned STAT_W      = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [3:0]  CTRL_RST    = 4'b0001,
  parameter logic [3:0]  MASK_RST    = 4'hF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk_i,
  input  logic              spi_cs_n_i,
  input  logic              spi_sdi_i,
  output logic              spi_sdo_o,
  input  logic [STAT_W-1:0] status_i,
  input  logic [3:0]        irq_src_i,
  output logic [3:0]        ctrl_o,
  output logic              irq_drive_low_o
);
  localparam int unsigned STAT_SLOTS = NIB_W - 1;

  logic     sclk_s, cs_s, sdi_s;
  logic     load, latch, shift;
  frame_t   sr, rd_byte;
  wr_word_t wr_q;
  logic [3:0] mask;
  logic     pend_q;
  logic [STAT_SLOTS-1:0] stat_field;

  daisy_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_sclk_i, spi_cs_n_i, spi_sdi_i}),
    .q({sclk_s, cs_s, sdi_s})
  );

  // inverted status, unused slots filled with ones
  for (genvar i = 0; i < int'(STAT_SLOTS); i++) begin : g_stat
    if (i < int'(STAT_W)) begin : g_used
      assign stat_field[i] = ~status_i[i];
    end else begin : g_fill
      assign stat_field[i] = 1'b1;
    end
  end

  assign rd_byte = {~pend_q, stat_field, MODULE_ID};

  daisy_shift u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_s(cs_s), .sdi_s(sdi_s),
    .rd_byte(rd_byte), .sr(sr), .load(load), .latch(latch), .shift(shift)
  );

  daisy_wlatch #(.CTRL_RST(CTRL_RST), .MASK_RST(MASK_RST)) u_wlatch (
    .clk(clk), .rst_n(rst_n), .latch(latch), .sr(sr), .wr_q(wr_q)
  );

  assign mask = wr_q.mask;

  daisy_irq #(.SRC_W(4)) u_irq (
    .clk(clk), .rst_n(rst_n), .src(irq_src_i), .mask(mask), .pend_q(pend_q)
  );

  assign spi_sdo_o       = sr[FRAME_W-1];
  assign ctrl_o          = wr_q.ctrl;
  assign irq_drive_low_o = pend_q;
endmodule

// File: rtl/daisy_node_chk.sv
module daisy_node_chk #(
  parameter logic [3:0] MODULE_ID = 4'h1,
  parameter logic [3:0] CTRL_RST  = 4'b0001
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_lvl,
  input logic       load,
  input logic       shift,
  input logic [7:0] sr,
  input logic       sdi_s,
  input logic [3:0] ctrl_o,
  input logic [3:0] mask,
  input logic [3:0] irq_src_i,
  input logic       irq_drive_low_o,
  input logic       spi_sdo_o
);
  AST_RESET_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ctrl_o == CTRL_RST && mask == 4'hF)); // R1

  AST_ID_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load) |-> sr[3:0] == MODULE_ID); // R2

  AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load) |-> spi_sdo_o == !$past(irq_drive_low_o)); // R3

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(shift) |-> sr[0] == $past(sdi_s)); // R4

  AST_HOLD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_lvl |=> ($stable(ctrl_o) && $stable(mask))); // R5

  AST_NO_SOURCE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_src_i == 4'h0) |=> !irq_drive_low_o); // R7

  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 4'hF) |=> !irq_drive_low_o); // R7

  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_lvl && $past(cs_lvl)) |-> $stable(spi_sdo_o)); // R8
endmodule

bind daisy_node daisy_node_chk #(.MODULE_ID(MODULE_ID), .CTRL_RST(CTRL_RST)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_lvl(cs_s), .load(load), .shift(shift),
  .sr(sr), .sdi_s(sdi_s), .ctrl_o(ctrl_o), .mask(mask),
  .irq_src_i(irq_src_i), .irq_drive_low_o(irq_drive_low_o),
  .spi_sdo_o(spi_sdo_o)
);

// File: tb/test_daisy_node.sv
module test_daisy_node;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b1;
  logic sdo;
  logic [1:0] status = 2'b00;
  logic [3:0] src = 4'h0;
  logic [3:0] ctrl;
  logic irq_low;

  int n_tests = 0;
  int n_fail  = 0;
  logic  exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  daisy_node #(.MODULE_ID(4'h1), .STAT_W(2), .SYNC_STAGES(2),
               .CTRL_RST(4'b0001), .MASK_RST(4'hF)) i_daisy_node (
    .clk(clk), .rst_n(rst_n), .spi_sclk_i(sclk), .spi_cs_n_i(cs_n),
    .spi_sdi_i(sdi), .spi_sdo_o(sdo), .status_i(status),
    .irq_src_i(src), .ctrl_o(ctrl), .irq_drive_low_o(irq_low)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected read byte: bit7 ~pending, bit6 filled, bits5:4 ~status, id 1
  function automatic logic [7:0] rd_exp(input logic pend, input logic [1:0] st);
    return {~pend, 1'b1, ~st, 4'h1};
  endfunction

  // scoreboard monitor: compare sdo at every serial rise inside a frame
  always @(posedge sclk) begin
    if (!cs_n) begin
      if (exp_q.size() == 0) chk("R3 queue empty", 8'(sdo), 8'hxx);
      else chk(tag_q.pop_front(), 8'(sdo), 8'(exp_q.pop_front()));
    end
  end

  task automatic frame(input int nbits, input logic [15:0] tx, input logic [15:0] exp_sdo,
                       input string tag, input logic [3:0] ctrl_hold,
                       input logic [1:0] st_after);
    @(negedge clk) cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = nbits - 1; i >= 0; i--) begin
      exp_q.push_back(exp_sdo[i]);
      tag_q.push_back(tag);
      sdi = tx[i];
      repeat (2) @(negedge clk);
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
      if (i == nbits - 1) status = st_after;
      if (i == nbits / 2) chk("R5 ctrl held mid-frame", 8'(ctrl), 8'(ctrl_hold));
      repeat (6) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    src = 4'b0001;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ctrl reset", 8'(ctrl), 8'h01);
    chk("R1 irq masked at reset", 8'(irq_low), 8'h00);
    chk("R1 sdo idle", 8'(sdo), 8'h01);

    // A: status 10, all masked -> read D1; write mask 1110 ctrl 0010
    status = 2'b10;
    frame(8, 16'h00E2, {8'h00, rd_exp(1'b0, 2'b10)}, "R2 R3 read byte A", 4'h1, 2'b10);
    chk("R6 ctrl after latch A", 8'(ctrl), 8'h02);
    repeat (2) @(negedge clk);
    chk("R7 unmasked source pulls low", 8'(irq_low), 8'h01);
    src = 4'b0010;
    repeat (2) @(negedge clk);
    chk("R7 masked source releases", 8'(irq_low), 8'h00);
    src = 4'b0001;
    repeat (2) @(negedge clk);

    // B: pending set, status 11 then changed after load
    status = 2'b11;
    frame(8, 16'h00F5, {8'h00, rd_exp(1'b1, 2'b11)}, "R2 capture at load B", 4'h2, 2'b00);
    chk("R6 ctrl after latch B", 8'(ctrl), 8'h05);
    repeat (2) @(negedge clk);
    chk("R7 all masked", 8'(irq_low), 8'h00);

    // C: 16-bit chained frame, pass-through delay of one byte
    status = 2'b00;
    frame(16, 16'h3C0A, {rd_exp(1'b0, 2'b00), 8'h3C}, "R4 chain pass-through", 4'h5, 2'b00);
    chk("R4 latch takes last byte", 8'(ctrl), 8'h0A);
    src = 4'h0;
    repeat (2) @(negedge clk);
    chk("R7 no source", 8'(irq_low), 8'h00);
    src = 4'b1000;
    repeat (2) @(negedge clk);
    chk("R7 unmasked bit3", 8'(irq_low), 8'h01);

    // D: serial clocks with chip select high are ignored
    chk("R8 sdo before idle clocks", 8'(sdo), 8'h00);
    sdi = 1'b1;
    for (int k = 0; k < 5; k++) begin
      sclk = 1'b1; repeat (8) @(negedge clk);
      sclk = 1'b0; repeat (8) @(negedge clk);
    end
    chk("R8 sdo after idle clocks", 8'(sdo), 8'h00);
    chk("R8 ctrl after idle clocks", 8'(ctrl), 8'h0A);

    // E: read after idle clocks still starts with this node's byte
    frame(8, 16'h00F1, {8'h00, rd_exp(1'b1, 2'b00)}, "R3 read byte E", 4'hA, 2'b00);
    chk("R6 ctrl after latch E", 8'(ctrl), 8'h01);
    chk("R3 scoreboard drained", 8'(exp_q.size()), 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule